// File: doc/BRIEF.md
# Automatic Entropy Request Sequencer

This block drives the command port of a random-number generator without software stepping it through each request. Software hands over one command word (normally an instantiate). Once the generator acknowledges it, and automatic mode is selected, the sequencer replays a stored generate command after every acknowledgement. A down-counter loaded from a programmable limit decides when a stored reseed command goes out instead of a generate.

Both stored commands live in small word stores, 13 words deep by default, that are filled by write strobes. Replay does not consume the stores: a shared read index steps through the words of a command and returns to the first word once the last word has been taken. Each command word is offered with a valid/ready handshake. An acknowledge input with a status bit closes each command.

Top module: `auto_req_seq`

## Requirements
- R1: Each store keeps at most 13 words, kept in write order. A write to a full store is dropped and sets `fatal_err_o`, which stays high until reset.
- R2: A software word is taken only while `sw_rdy_o` is high, and is then sent once on the command port. While `cmd_valid_o` is high and `cmd_ready_i` is low, the word on `cmd_data_o` holds steady.
- R3: The acknowledge of a software command raises `done_irq_o` for exactly one cycle. An acknowledge of an automatic command leaves it low. Every acknowledge copies `ack_sts_i` into `sts_o` (0 = success, 1 = error).
- R4: In automatic mode, after the software command is acknowledged, the generate store's words are sent in write order. Each later command starts only after the previous one has been acknowledged. The stores are replayed, not drained.
- R5: The countdown loads `reseed_limit_i` at the software acknowledge and drops by one after each generate command. When it reads zero at an acknowledge and the reseed store is not empty, the reseed command is sent and the countdown is reloaded. A limit of L therefore gives L generates between reseeds.
- R6: In automatic mode, once the first software command has been acknowledged, `sw_rdy_o` stays low and software words are ignored until `enable_i` drops.
- R7: While `fifo_clr_i` is high, both stores are emptied and writes to them are ignored.
- R8: When `enable_i` is low at an acknowledge, the sequencer goes idle and sends no further words, and `sw_rdy_o` returns high.
- R9: Without automatic mode, the sequencer returns to idle after the software acknowledge and issues nothing on its own.
- R10: After reset, `cmd_valid_o`, `done_irq_o`, `fatal_err_o` and `sts_o` are low and `sw_rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Sequencer enable |
| auto_mode_i | input | 1 | Replay stored commands after the software command |
| fifo_clr_i | input | 1 | Empty both command stores |
| gen_wr_i | input | 1 | Append `wr_data_i` to the generate store |
| res_wr_i | input | 1 | Append `wr_data_i` to the reseed store |
| wr_data_i | input | 32 | Store write word |
| sw_cmd_valid_i | input | 1 | Software command word strobe |
| sw_cmd_i | input | 32 | Software command word |
| reseed_limit_i | input | 32 | Generates between reseeds |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_data_o | output | 32 | Command word |
| cmd_ready_i | input | 1 | Generator takes the word |
| ack_i | input | 1 | Command acknowledge |
| ack_sts_i | input | 1 | Acknowledge status, 1 = error |
| sts_o | output | 1 | Status of the last acknowledge |
| sw_rdy_o | output | 1 | Software word may be written |
| done_irq_o | output | 1 | One-cycle pulse at the software acknowledge |
| fatal_err_o | output | 1 | Sticky store overflow |

## Verification
The assertions assume that the generator raises `ack_i` only after it has taken the last word of a command, that `fifo_clr_i` and store writes do not occur in the middle of a command, and that enable, mode and limit change only while a command is waiting for its acknowledge or the block is idle. The bench keeps to these rules. It pulses acknowledge only after its scoreboard has emptied, and it changes stores and modes only in idle or acknowledge-wait phases. It also throttles `cmd_ready_i` on a fixed three-cycle pattern so that every command sees backpressure.

// File: rtl/auto_req_seq_pkg.sv
package auto_req_seq_pkg;

    localparam int SEQ_WORD_W = 32;
    localparam int SEQ_DEPTH  = 13;
    localparam int SEQ_CNT_W  = 32;

    localparam int GEN_SLOT = 0;
    localparam int RES_SLOT = 1;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_SW_SEND  = 3'd1,
        S_SW_ACK   = 3'd2,
        S_GEN      = 3'd3,
        S_RES      = 3'd4,
        S_AUTO_ACK = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic dec;
    } ctr_op_t;

    function automatic logic is_last_word(input logic [15:0] idx, input logic [15:0] cnt);
        return (idx + 16'd1) >= cnt;
    endfunction

endpackage

// File: rtl/cmd_store.sv
module cmd_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 13
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         wr_i,
    input  logic [WORD_W-1:0]            wr_data_i,
    input  logic [$clog2(DEPTH+1)-1:0]   rd_idx_i,
    output logic [WORD_W-1:0]            rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         ovf_o
);
    localparam int IDX_W = $clog2(DEPTH+1);
    localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);
    localparam logic [IDX_W-1:0] ONE_L   = IDX_W'(1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  cnt_q;
    logic              take;

    assign take  = wr_i && !clr_i && (cnt_q < DEPTH_L);
    assign ovf_o = wr_i && !clr_i && (cnt_q == DEPTH_L);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + ONE_L;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            mem[cnt_q] <= wr_data_i;
        end
    end

    assign rd_data_o = (rd_idx_i < DEPTH_L) ? mem[rd_idx_i] : '0;
    assign count_o   = cnt_q;

    AST_STORE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DEPTH_L); // R1
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == DEPTH_L && wr_i && !clr_i) |=> cnt_q == DEPTH_L); // R1
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0); // R7

endmodule

// File: rtl/reseed_ctr.sv
module reseed_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= limit_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE_C;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(limit_i)); // R5
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i && !zero_o) |=> cnt_q == $past(cnt_q) - ONE_C); // R5

endmodule

// File: rtl/auto_req_seq.sv
module auto_req_seq
    import auto_req_seq_pkg::*;
#(
    parameter int WORD_W = SEQ_WORD_W,
    parameter int DEPTH  = SEQ_DEPTH,
    parameter int CNT_W  = SEQ_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              auto_mode_i,
    input  logic              fifo_clr_i,
    input  logic              gen_wr_i,
    input  logic              res_wr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              sw_cmd_valid_i,
    input  logic [WORD_W-1:0] sw_cmd_i,
    input  logic [CNT_W-1:0]  reseed_limit_i,
    output logic              cmd_valid_o,
    output logic [WORD_W-1:0] cmd_data_o,
    input  logic              cmd_ready_i,
    input  logic              ack_i,
    input  logic              ack_sts_i,
    output logic              sts_o,
    output logic              sw_rdy_o,
    output logic              done_irq_o,
    output logic              fatal_err_o
);
    localparam int IDX_W = $clog2(DEPTH+1);
    localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  rd_idx_q;
    logic              sw_pend_q, lock_q, lock_set;
    logic [WORD_W-1:0] sw_word_q;
    logic              sts_q, done_q, fatal_q;
    logic              fire, last_word, ctr_zero;
    ctr_op_t           ctr_op;

    logic [WORD_W-1:0] st_rd  [2];
    logic [IDX_W-1:0]  st_cnt [2];
    logic              st_ovf [2];
    logic              st_wr  [2];

    assign st_wr[GEN_SLOT] = gen_wr_i;
    assign st_wr[RES_SLOT] = res_wr_i;

    for (genvar g = 0; g < 2; g++) begin : g_store
        cmd_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
            .clk       (clk),
            .rst       (rst),
            .clr_i     (fifo_clr_i),
            .wr_i      (st_wr[g]),
            .wr_data_i (wr_data_i),
            .rd_idx_i  (rd_idx_q),
            .rd_data_o (st_rd[g]),
            .count_o   (st_cnt[g]),
            .ovf_o     (st_ovf[g])
        );
    end

    reseed_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctr_op.load),
        .dec_i   (ctr_op.dec),
        .limit_i (reseed_limit_i),
        .zero_o  (ctr_zero)
    );

    // Output word selection
    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_data_o  = '0;
        unique case (state_q)
            S_SW_SEND: begin cmd_valid_o = 1'b1; cmd_data_o = sw_word_q;       end
            S_GEN:     begin cmd_valid_o = 1'b1; cmd_data_o = st_rd[GEN_SLOT]; end
            S_RES:     begin cmd_valid_o = 1'b1; cmd_data_o = st_rd[RES_SLOT]; end
            default: ;
        endcase
    end

    assign fire      = cmd_valid_o && cmd_ready_i;
    assign last_word = is_last_word(16'(rd_idx_q),
                       16'((state_q == S_RES) ? st_cnt[RES_SLOT] : st_cnt[GEN_SLOT]));

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        ctr_op   = '0;
        lock_set = 1'b0;
        unique case (state_q)
            S_IDLE:    if (enable_i && sw_pend_q) state_d = S_SW_SEND;
            S_SW_SEND: if (fire) state_d = S_SW_ACK;
            S_SW_ACK: if (ack_i) begin
                if (auto_mode_i && enable_i) begin
                    lock_set    = 1'b1;
                    ctr_op.load = 1'b1;
                    state_d     = (st_cnt[GEN_SLOT] != '0) ? S_GEN : S_IDLE;
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_GEN: if (fire && last_word) begin
                ctr_op.dec = 1'b1;
                state_d    = S_AUTO_ACK;
            end
            S_RES: if (fire && last_word) begin
                ctr_op.load = 1'b1;
                state_d     = S_AUTO_ACK;
            end
            S_AUTO_ACK: if (ack_i) begin
                if (!enable_i)                                  state_d = S_IDLE;
                else if (ctr_zero && st_cnt[RES_SLOT] != '0)    state_d = S_RES;
                else if (st_cnt[GEN_SLOT] != '0)                state_d = S_GEN;
                else                                            state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign sw_rdy_o = (state_q == S_IDLE) && !sw_pend_q && !lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            rd_idx_q  <= '0;
            sw_pend_q <= 1'b0;
            sw_word_q <= '0;
            lock_q    <= 1'b0;
            sts_q     <= 1'b0;
            done_q    <= 1'b0;
            fatal_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire && (state_q == S_GEN || state_q == S_RES)) begin
                rd_idx_q <= last_word ? '0 : rd_idx_q + ONE_I;
            end
            if (sw_cmd_valid_i && sw_rdy_o) begin
                sw_pend_q <= 1'b1;
                sw_word_q <= sw_cmd_i;
            end else if (state_q == S_SW_SEND && fire) begin
                sw_pend_q <= 1'b0;
            end
            if (!enable_i)     lock_q <= 1'b0;
            else if (lock_set) lock_q <= 1'b1;
            if (ack_i && (state_q == S_SW_ACK || state_q == S_AUTO_ACK)) begin
                sts_q <= ack_sts_i;
            end
            done_q  <= ack_i && (state_q == S_SW_ACK);
            fatal_q <= fatal_q || st_ovf[GEN_SLOT] || st_ovf[RES_SLOT];
        end
    end

    assign sts_o       = sts_q;
    assign done_irq_o  = done_q;
    assign fatal_err_o = fatal_q;

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o))); // R2
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |-> $past(ack_i)); // R3
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fatal_err_o |=> fatal_err_o); // R1
    AST_SW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sw_cmd_valid_i && lock_q) |=> !sw_pend_q); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_AUTO_ACK && ack_i && !enable_i) |=> !cmd_valid_o); // R8

endmodule

// File: tb/sim_auto_req_seq.sv
module sim_auto_req_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0, auto_mode_i = 1'b0, fifo_clr_i = 1'b0;
    logic        gen_wr_i = 1'b0, res_wr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        sw_cmd_valid_i = 1'b0;
    logic [31:0] sw_cmd_i = '0;
    logic [31:0] reseed_limit_i = '0;
    logic        cmd_valid_o;
    logic [31:0] cmd_data_o;
    logic        cmd_ready_i = 1'b0;
    logic        ack_i = 1'b0, ack_sts_i = 1'b0;
    logic        sts_o, sw_rdy_o, done_irq_o, fatal_err_o;

    int          n_tests = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       cur_req = "R2";

    auto_req_seq u0 (
        .clk(clk), .rst(rst), .enable_i(enable_i), .auto_mode_i(auto_mode_i),
        .fifo_clr_i(fifo_clr_i), .gen_wr_i(gen_wr_i), .res_wr_i(res_wr_i),
        .wr_data_i(wr_data_i), .sw_cmd_valid_i(sw_cmd_valid_i), .sw_cmd_i(sw_cmd_i),
        .reseed_limit_i(reseed_limit_i), .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o),
        .cmd_ready_i(cmd_ready_i), .ack_i(ack_i), .ack_sts_i(ack_sts_i), .sts_o(sts_o),
        .sw_rdy_o(sw_rdy_o), .done_irq_o(done_irq_o), .fatal_err_o(fatal_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ready throttle: low one cycle in three
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            cmd_ready_i = (k % 3) != 2;
            k++;
        end
    end

    // Monitor: pop expected words as they are handed over
    always @(negedge clk) begin
        if (!rst && cmd_valid_o && cmd_ready_i) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected word actual %h expected none", cur_req, cmd_data_o);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (cmd_data_o !== e) begin
                    n_fail++;
                    $display("FAIL %s: word actual %h expected %h", cur_req, cmd_data_o, e);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input logic cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_store(input bit res, input logic [31:0] w);
        wr_data_i = w;
        if (res) res_wr_i = 1'b1; else gen_wr_i = 1'b1;
        tick();
        gen_wr_i = 1'b0; res_wr_i = 1'b0;
    endtask

    task automatic sw_write(input logic [31:0] w);
        sw_cmd_i = w; sw_cmd_valid_i = 1'b1;
        tick();
        sw_cmd_valid_i = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        cur_req = req;
        while (exp_q.size() != 0 && guard < 500) begin
            tick();
            guard++;
        end
        check(exp_q.size() == 0, req, "words left", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tick();
    endtask

    task automatic ack(input logic s);
        ack_sts_i = s; ack_i = 1'b1;
        tick();
        ack_i = 1'b0; ack_sts_i = 1'b0;
    endtask

    task automatic push_gen3();
        exp_q.push_back(32'h6000_0000); exp_q.push_back(32'h6000_0001); exp_q.push_back(32'h6000_0002);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check(cmd_valid_o == 1'b0, "R10", "cmd_valid_o", 32'(cmd_valid_o), 32'd0);
        check(sw_rdy_o == 1'b1,    "R10", "sw_rdy_o",    32'(sw_rdy_o),    32'd1);
        check(fatal_err_o == 1'b0 && done_irq_o == 1'b0 && sts_o == 1'b0, "R10",
              "fatal/done/sts", {29'd0, fatal_err_o, done_irq_o, sts_o}, 32'd0);

        // Manual mode: R9, R2, R3
        enable_i = 1'b1; auto_mode_i = 1'b0;
        sw_write(32'hA000_0001);
        check(sw_rdy_o == 1'b0, "R2", "sw_rdy_o while pending", 32'(sw_rdy_o), 32'd0);
        exp_q.push_back(32'hA000_0001);
        drain("R2");
        ack(1'b1);
        check(done_irq_o == 1'b1, "R3", "done_irq_o at sw ack", 32'(done_irq_o), 32'd1);
        check(sts_o == 1'b1,      "R3", "sts_o error",          32'(sts_o),      32'd1);
        tick();
        check(done_irq_o == 1'b0, "R3", "done_irq_o one cycle", 32'(done_irq_o), 32'd0);
        cur_req = "R9";
        repeat (10) tick();
        check(cmd_valid_o == 1'b0 && sw_rdy_o == 1'b1, "R9", "idle after manual ack",
              {30'd0, cmd_valid_o, sw_rdy_o}, 32'd1);
        sw_write(32'hA000_0002);
        exp_q.push_back(32'hA000_0002);
        drain("R2");
        ack(1'b0);
        check(sts_o == 1'b0, "R3", "sts_o success", 32'(sts_o), 32'd0);

        // Automatic mode: R4, R5, R6
        for (int i = 0; i < 3; i++) wr_store(1'b0, 32'h6000_0000 + 32'(i));
        wr_store(1'b1, 32'h7000_0000);
        wr_store(1'b1, 32'h7000_0001);
        reseed_limit_i = 32'd2;
        auto_mode_i = 1'b1;
        sw_write(32'h1111_0001);
        exp_q.push_back(32'h1111_0001);
        drain("R2");
        ack(1'b0);
        check(done_irq_o == 1'b1, "R3", "done at instantiate ack", 32'(done_irq_o), 32'd1);
        check(sw_rdy_o == 1'b0,   "R6", "sw_rdy_o locked",         32'(sw_rdy_o),   32'd0);
        for (int i = 0; i < 6; i++) begin
            if (i == 2 || i == 5) begin
                exp_q.push_back(32'h7000_0000); exp_q.push_back(32'h7000_0001);
            end else begin
                push_gen3();
            end
            if (i == 1) sw_write(32'hBAD0_0BAD); // R6: must never appear
            drain((i == 2 || i == 5) ? "R5" : "R4");
            if (i == 0) begin
                cur_req = "R4";
                repeat (5) tick();
                check(cmd_valid_o == 1'b0, "R4", "no word before ack", 32'(cmd_valid_o), 32'd0);
            end
            if (i == 5) enable_i = 1'b0;
            ack(1'b0);
            if (i == 0) check(done_irq_o == 1'b0, "R3", "no done at auto ack", 32'(done_irq_o), 32'd0);
        end
        cur_req = "R8";
        repeat (20) tick();
        check(cmd_valid_o == 1'b0, "R8", "silent after disable", 32'(cmd_valid_o), 32'd0);
        check(sw_rdy_o == 1'b1,    "R8", "sw_rdy_o back",         32'(sw_rdy_o),    32'd1);

        // Clear and depth: R7, R1
        fifo_clr_i = 1'b1;
        tick();
        wr_store(1'b0, 32'h0000_0077); // ignored while clearing
        fifo_clr_i = 1'b0;
        tick();
        for (int i = 0; i < 13; i++) wr_store(1'b0, 32'hC000_0000 + 32'(i));
        check(fatal_err_o == 1'b0, "R1", "fatal after 13 words", 32'(fatal_err_o), 32'd0);
        wr_store(1'b0, 32'hEEEE_EEEE);
        check(fatal_err_o == 1'b1, "R1", "fatal after 14th word", 32'(fatal_err_o), 32'd1);
        repeat (3) tick();
        check(fatal_err_o == 1'b1, "R1", "fatal sticky", 32'(fatal_err_o), 32'd1);
        reseed_limit_i = 32'd0; // reseed store is empty after clear, so only generates
        enable_i = 1'b1;
        sw_write(32'h1111_0002);
        exp_q.push_back(32'h1111_0002);
        drain("R2");
        ack(1'b0);
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 13; i++) exp_q.push_back(32'hC000_0000 + 32'(i));
            drain("R7");
            if (r == 1) enable_i = 1'b0;
            ack(1'b0);
        end
        cur_req = "R8";
        repeat (20) tick();
        check(cmd_valid_o == 1'b0, "R8", "silent at end", 32'(cmd_valid_o), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule